// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources on behalf of a primary interrupt controller. Software enables sources one by one through a pair of write-one-to-set and write-one-to-clear enable registers. It reads back the enabled pending sources, or the raw source levels, over a simple APB-style register bus. Every enabled source that is not diverted is ORed into a single cascade output. That output is wired to primary input line 31.

Some sources are better served by a line of their own on the primary controller. A per-source pass-through register routes a source straight to the primary line with the same index and takes it out of the cascade OR. That source then cannot signal the primary twice. Only sources marked in a build-time capability mask can be passed through; the default marks sources 20 to 31.

No source is latched. Every status bit and every output follows its input level in the same cycle. An interrupt is cleared at the peripheral that raised it.

Top module: `sic_cascade`

## Requirements
- R1: A bus write to offset 0x08 sets enable bit n for every bit n that is 1 in the written word. Bits written as 0 leave their enable unchanged. No other access changes the enables. Reads at 0x08 or 0x0C return the current enable word.
- R2: A bus write to offset 0x0C clears enable bit n for every 1 in the written word. Writing 0xFFFFFFFF disables every source.
- R3: A read at offset 0x00 returns the source levels ANDed with the enable bits. A value of 0 means no enabled source is pending.
- R4: A read at offset 0x04 returns the unmasked source levels.
- R5: `cascade_o` is high exactly when some source is pending, enabled and not passed through.
- R6: `direct_o[n]` equals source n ANDed with pass-through bit n. This path is not gated by the enable bits.
- R7: A write to offset 0x10 loads the pass-through word ANDed with the capability mask `PT_CAPABLE` (default 0xFFF00000). Bits outside the mask stay 0. A read at 0x10 returns the stored word.
- R8: Sources are level-sensitive. When a source falls, its status bit and its contribution to `cascade_o` fall in the same cycle, with no write to the block.
- R9: After reset all enable and pass-through bits are 0. `cascade_o` and `direct_o` are then low whatever the source levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write, 1 = write |
| paddr_i | input | ADDR_W | Bus byte address |
| pwdata_i | input | NUM_SRC | Bus write data |
| prdata_o | output | NUM_SRC | Bus read data |
| cascade_o | output | 1 | Combined interrupt to primary line 31 |
| direct_o | output | NUM_SRC | Passed-through sources to the same-numbered primary lines |

## Verification
The assertions check every cycle that a write to the set or clear register updates the enable word exactly as written, and that no other cycle alters it. They also check that `cascade_o` is never high without a pending, enabled source that is not passed through, and that `direct_o` stays within the pass-through word and the capability mask. The scenarios of the bench show the rest. They cover the exact values of the status and raw reads, the interaction of set, clear and pass-through writes across several source patterns, and the discarding of pass-through bits outside the capability mask. They also show outputs falling with their source and not being held, and the reset state.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned OFF_STAT = 'h00;
  localparam int unsigned OFF_RAW  = 'h04;
  localparam int unsigned OFF_SET  = 'h08;
  localparam int unsigned OFF_CLR  = 'h0C;
  localparam int unsigned OFF_PT   = 'h10;

  typedef enum logic [2:0] {
    SEL_STAT,
    SEL_RAW,
    SEL_SET,
    SEL_CLR,
    SEL_PT,
    SEL_NONE
  } sic_sel_e;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int unsigned        NUM_SRC    = 32,
  parameter int unsigned        ADDR_W     = 8,
  parameter logic [NUM_SRC-1:0] PT_CAPABLE = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [NUM_SRC-1:0] pwdata_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] stat_i,
  output logic [NUM_SRC-1:0] prdata_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pt_o
);
  logic [NUM_SRC-1:0] en_q, pt_q;
  sic_sel_e           sel;
  logic               wr;

  always_comb begin
    if      (paddr_i == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (paddr_i == ADDR_W'(OFF_RAW))  sel = SEL_RAW;
    else if (paddr_i == ADDR_W'(OFF_SET))  sel = SEL_SET;
    else if (paddr_i == ADDR_W'(OFF_CLR))  sel = SEL_CLR;
    else if (paddr_i == ADDR_W'(OFF_PT))   sel = SEL_PT;
    else                                   sel = SEL_NONE;
  end

  assign wr = psel_i & penable_i & pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      pt_q <= '0;
    end else if (wr) begin
      unique case (sel)
        SEL_SET: en_q <= en_q | pwdata_i;
        SEL_CLR: en_q <= en_q & ~pwdata_i;
        SEL_PT:  pt_q <= pwdata_i & PT_CAPABLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STAT:         prdata_o = stat_i;
      SEL_RAW:          prdata_o = src_i;
      SEL_SET, SEL_CLR: prdata_o = en_q;
      SEL_PT:           prdata_o = pt_q;
      default:          prdata_o = '0;
    endcase
  end

  assign en_o = en_q;
  assign pt_o = pt_q;

  // R1
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && paddr_i == ADDR_W'(OFF_SET)) |=> en_q == ($past(en_q) | $past(pwdata_i)));

  // R2
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && paddr_i == ADDR_W'(OFF_CLR)) |=> en_q == ($past(en_q) & ~$past(pwdata_i)));

  // R1
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (paddr_i == ADDR_W'(OFF_SET) || paddr_i == ADDR_W'(OFF_CLR))) |=> $stable(en_q));

  // R7
  pt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && paddr_i == ADDR_W'(OFF_PT)) |=> $stable(pt_q));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] pt_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] direct_o,
  output logic               cascade_o
);
  logic [NUM_SRC-1:0] casc_bits;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign stat_o[i]    = src_i[i] & en_i[i];
    assign direct_o[i]  = src_i[i] & pt_i[i];
    // passed-through sources leave the cascade
    assign casc_bits[i] = stat_o[i] & ~pt_i[i];
  end

  assign cascade_o = |casc_bits;

  // R5
  casc_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_o |-> |(src_i & en_i & ~pt_i));

  // R8
  stat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (stat_o == '0 && !cascade_o && direct_o == '0));
endmodule

// File: rtl/sic_cascade.sv
module sic_cascade
  import sic_pkg::*;
#(
  parameter int unsigned        NUM_SRC    = 32,
  parameter int unsigned        ADDR_W     = 8,
  parameter logic [NUM_SRC-1:0] PT_CAPABLE = NUM_SRC'(32'hFFF0_0000)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [NUM_SRC-1:0] pwdata_i,
  output logic [NUM_SRC-1:0] prdata_o,
  output logic               cascade_o,
  output logic [NUM_SRC-1:0] direct_o
);
  logic [NUM_SRC-1:0] en, pt, stat;

  sic_regs #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .PT_CAPABLE(PT_CAPABLE)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .src_i    (src_i),
    .stat_i   (stat),
    .prdata_o (prdata_o),
    .en_o     (en),
    .pt_o     (pt)
  );

  sic_route #(
    .NUM_SRC(NUM_SRC)
  ) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .en_i     (en),
    .pt_i     (pt),
    .stat_o   (stat),
    .direct_o (direct_o),
    .cascade_o(cascade_o)
  );

  // R6
  direct_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((direct_o & ~pt) == '0) && ((direct_o & ~PT_CAPABLE) == '0));

  // R7
  pt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt & ~PT_CAPABLE) == '0);
endmodule

// File: tb/sim_sic_cascade.sv
module sim_sic_cascade;
  localparam int unsigned NUM_SRC = 32;
  localparam int unsigned ADDR_W  = 8;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_SRC-1:0] src = '0;
  logic               psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0]  paddr = '0;
  logic [NUM_SRC-1:0] pwdata = '0;
  logic [NUM_SRC-1:0] prdata;
  logic               cascade;
  logic [NUM_SRC-1:0] direct;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sic_cascade u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .cascade_o(cascade), .direct_o(direct)
  );

  typedef struct packed {
    logic [31:0] set_w;
    logic [31:0] clr_w;
    logic [31:0] pt_w;
    logic [31:0] src_v;
    logic [31:0] stat;
    logic [31:0] dir;
    logic        casc;
  } vec_t;

  // cumulative: each row writes set, clear, pass-through, then drives sources
  localparam vec_t VECS [7] = '{
    '{32'h0000_00FF, 32'h0, 32'h0, 32'h0000_0F0F, 32'h0000_000F, 32'h0, 1'b1},
    '{32'hFFFF_0000, 32'h0000_000F, 32'h0, 32'h8000_000F, 32'h8000_0000, 32'h0, 1'b1},
    '{32'h0, 32'h0, 32'hFFD0_0000, 32'h8000_000F, 32'h8000_0000, 32'h8000_0000, 1'b0},
    '{32'h0, 32'h0, 32'hFFD0_0000, 32'h0020_0010, 32'h0020_0010, 32'h0, 1'b1},
    '{32'h0, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0},
    '{32'h0010_0000, 32'h0, 32'h0010_0000, 32'h0010_0000, 32'h0010_0000, 32'h0010_0000, 1'b0},
    '{32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0010_0001, 32'h0010_0000, 32'h0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got %08h expected %08h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R9: reset state, outputs low even with all sources high
    bus_rd(8'h08, rd);  chk("R9 enable after reset", rd, 32'h0);
    bus_rd(8'h10, rd);  chk("R9 pass-through after reset", rd, 32'h0);
    drive_src(32'hFFFF_FFFF);
    chk("R9 cascade after reset", {31'h0, cascade}, 32'h0);
    chk("R9 direct after reset", direct, 32'h0);
    drive_src(32'h0);

    // table walk
    for (int i = 0; i < 7; i++) begin
      bus_wr(8'h08, VECS[i].set_w);
      bus_wr(8'h0C, VECS[i].clr_w);
      bus_wr(8'h10, VECS[i].pt_w);
      drive_src(VECS[i].src_v);
      chk("R5 cascade vector", {31'h0, cascade}, {31'h0, VECS[i].casc});
      chk("R6 direct vector", direct, VECS[i].dir);
      bus_rd(8'h00, rd);  chk("R3 masked status vector", rd, VECS[i].stat);
      bus_rd(8'h04, rd);  chk("R4 raw status vector", rd, VECS[i].src_v);
    end

    // R7: bits outside the capability mask are dropped
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, rd);  chk("R7 pass-through capability", rd, 32'hFFF0_0000);
    drive_src(32'h000F_FFFF);
    chk("R7 direct on incapable sources", direct, 32'h0);
    bus_wr(8'h10, 32'h0);

    // R1: zero bits leave enables alone; reads do not change them
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_wr(8'h08, 32'h0000_A5A5);
    bus_wr(8'h08, 32'h0);
    bus_rd(8'h00, rd);
    bus_rd(8'h0C, rd);  chk("R1 set with zero word", rd, 32'h0000_A5A5);
    bus_wr(8'h08, 32'h0001_0001);
    bus_rd(8'h08, rd);  chk("R1 set accumulates", rd, 32'h0001_A5A5);

    // R2: clear only the ones written
    bus_wr(8'h0C, 32'h0000_0505);
    bus_rd(8'h08, rd);  chk("R2 partial clear", rd, 32'h0001_A0A0);

    // R8: level-sensitive, nothing latched
    drive_src(32'h0000_0020);
    chk("R8 cascade with source high", {31'h0, cascade}, 32'h1);
    drive_src(32'h0);
    chk("R8 cascade after source falls", {31'h0, cascade}, 32'h0);
    bus_rd(8'h00, rd);  chk("R8 status after source falls", rd, 32'h0);

    // R2: full clear disables everything
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    drive_src(32'hFFFF_FFFF);
    chk("R2 cascade after full clear", {31'h0, cascade}, 32'h0);
    bus_rd(8'h00, rd);  chk("R2 status after full clear", rd, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule